// File: doc/BRIEF.md
# Sample Input Select and Channel Demultiplex Front End

This block is the first stage of one digital downconverter channel. It takes one of four 16-bit parallel sample buses or a test word written by the processor. It qualifies each sample with an enable, and it can pick one channel out of a time-multiplexed stream of up to eight channels. The word it passes on is always 16-bit two's complement, with a valid strobe, ready for the mixer that follows.

Two timing modes are offered. In gated mode the pipeline advances only on enabled clocks, so downstream processing stalls between samples. In interpolated mode the pipeline runs on every clock and feeds zeros wherever the enable is low, which stuffs zeros between real samples up to the clock rate.

Channel extraction uses a programmable delay on the frame enable. That delay clocks a capture register. A second register, clocked by the undelayed frame enable, releases the captured sample so that every channel leaves at the same instant within the frame. Input words can be fixed point, in two's complement or offset binary, or floating point with one of four mantissa/exponent splits.

Top module: `sample_front_end`

## Requirements
- R1: `src_sel` values 0, 1, 2 and 3 pick bus A, B, C and D, which are `bus_data` bits [15:0], [31:16], [47:32] and [63:48]. When `use_test_data` is 1, `test_word` replaces the bus word.
- R2: When `use_test_en` is 1, the sample enable is `test_en`, which is active high. Otherwise it is the inverse of `bus_en_n[src_sel]`, which is active low. The enables of the buses that are not selected have no effect.
- R3: After reset, `out_valid` and `out_data` are 0 and every enable is blocked. An enable admitted in the same clock as the first `sync_in` pulse is still blocked. From the next clock on, enables pass. With a continuous enable, the first valid output appears 4 clocks after the sync clock.
- R4: Gated mode (`interp_mode`=0). Each enabled clock captures one sample. If a sample was captured earlier, that earlier sample is released as one valid output. Without an enable, `out_valid` stays 0 and `out_data` holds its value.
- R5: Interpolated mode (`interp_mode`=1, after sync). `out_valid` is 1 on every clock. A sample driven in clock k appears on `out_data` 3 clocks later. A clock whose enable is low yields 0x0000.
- R6: Demultiplex in gated mode. A one-clock enable marks channel 0 of a frame, and channel c arrives c clocks later. A `demux_dly` value of d captures channel d. That sample leaves as a valid output at the next frame's enable.
- R7: In fixed point (`float_en`=0), `offset_bin`=1 inverts bit 15, and `offset_bin`=0 passes the word unchanged. In floating point, `offset_bin` is ignored.
- R8: In floating point (`float_en`=1), `float_split` selects the layout. Code 0 is an 11-bit mantissa in [13:3] with a 3-bit exponent in [2:0]. Code 1 is a 12-bit mantissa in [14:3] with the exponent in [2:0]. Code 2 is a 13-bit mantissa in [15:3] with the exponent in [2:0]. Code 3 is a 14-bit mantissa in [15:2] with a 2-bit exponent in [1:0]. The output is the signed mantissa shifted left by the exponent, and any bits above the mantissa are ignored.
- R9: A float result above 32767 gives 0x7FFF, and one below -32768 gives 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_data | input | 64 | Four 16-bit sample buses, A in the low bits |
| bus_en_n | input | 4 | Per-bus sample enable, active low |
| test_word | input | 16 | Processor-written test sample |
| test_en | input | 1 | Test enable, active high |
| src_sel | input | 2 | Bus select |
| use_test_data | input | 1 | Take `test_word` instead of a bus |
| use_test_en | input | 1 | Take `test_en` instead of the bus enable |
| interp_mode | input | 1 | 1 = interpolated, 0 = gated |
| offset_bin | input | 1 | Fixed-point word is offset binary |
| float_en | input | 1 | Input word is floating point |
| float_split | input | 2 | Mantissa/exponent layout code |
| demux_dly | input | 3 | Channel pick delay, 0 to 7 |
| sync_in | input | 1 | Sync pulse that admits enables |
| out_data | output | 16 | Two's-complement sample |
| out_valid | output | 1 | Sample strobe |

## Verification
A fault in the capture or release registers shows up as a stream that is off by one frame or shows a stale word, and this is visible at the first released sample after the fault. A wrong tap in the enable delay line picks the wrong channel, which shows in the low bits of every demultiplexed output within one frame. A fault in the sync latch or the enable selection shows up as valid strobes before sync or from a bus that was not selected, within four clocks. Conversion faults show up at once in the value of the output word.

// File: rtl/sample_front_end.sv
module sample_front_end #(
  parameter int NBUS  = 4,
  parameter int MAXCH = 8,
  localparam int SW = $clog2(NBUS),
  localparam int DW = $clog2(MAXCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBUS*16-1:0] bus_data,
  input  logic [NBUS-1:0]   bus_en_n,
  input  logic [15:0]       test_word,
  input  logic              test_en,
  input  logic [SW-1:0]     src_sel,
  input  logic              use_test_data,
  input  logic              use_test_en,
  input  logic              interp_mode,
  input  logic              offset_bin,
  input  logic              float_en,
  input  logic [1:0]        float_split,
  input  logic [DW-1:0]     demux_dly,
  input  logic              sync_in,
  output logic [15:0]       out_data,
  output logic              out_valid
);

  logic [15:0] raw_word, conv_word, d1, sel_q;
  logic armed_q, run_q, e1, sel_v;
  logic en_pick, en_ok, tap, tick_cap, tick_al;
  logic [MAXCH-1:1] edly;

  function automatic logic [15:0] expand(input logic [15:0] w, input logic [1:0] spl);
    logic signed [31:0] m, v;
    logic [2:0] e;
    case (spl)
      2'd0:    begin m = {{21{w[13]}}, w[13:3]}; e = w[2:0]; end
      2'd1:    begin m = {{20{w[14]}}, w[14:3]}; e = w[2:0]; end
      2'd2:    begin m = {{19{w[15]}}, w[15:3]}; e = w[2:0]; end
      default: begin m = {{18{w[15]}}, w[15:2]}; e = {1'b0, w[1:0]}; end
    endcase
    v = m <<< e;
    if (v > 32'sd32767)       expand = 16'h7fff;
    else if (v < -32'sd32768) expand = 16'h8000;
    else                      expand = v[15:0];
  endfunction

  assign raw_word  = use_test_data ? test_word : bus_data[src_sel*16 +: 16];
  assign conv_word = float_en ? expand(raw_word, float_split)
                              : {raw_word[15] ^ offset_bin, raw_word[14:0]};
  assign en_pick   = use_test_en ? test_en : ~bus_en_n[src_sel];
  assign en_ok     = en_pick & armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      e1      <= 1'b0;
      d1      <= '0;
      edly    <= '0;
    end else begin
      armed_q <= armed_q | sync_in;
      run_q   <= armed_q;
      e1      <= en_ok;
      d1      <= (interp_mode && !en_ok) ? 16'h0000 : conv_word;
      edly    <= {edly[MAXCH-2:1], e1};
    end
  end

  assign tap      = (demux_dly == '0) ? e1 : edly[demux_dly];
  assign tick_cap = interp_mode ? run_q : tap;
  assign tick_al  = interp_mode ? run_q : e1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      sel_v     <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      if (tick_cap) begin
        sel_q <= d1;
        sel_v <= 1'b1;
      end
      if (tick_al) out_data <= sel_q;
      out_valid <= tick_al & sel_v;
    end
  end

  // R3
  valid_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> armed_q);

  // R4
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!interp_mode && $past(!interp_mode) && !out_valid) |-> $stable(out_data));

  // R5
  interp_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(interp_mode) && $past(run_q) && $past(sel_v)) |-> out_valid);

  // R6
  demux_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (demux_dly == 3'd2 && $past(demux_dly) == 3'd2 && $past(demux_dly, 2) == 3'd2
     && $past(e1, 2)) |-> tap);

endmodule

// File: tb/sim_sample_front_end.sv
`timescale 1ns/1ps
module sim_sample_front_end;
  logic clk = 0, rst_n = 0;
  logic [63:0] bus_data = '0;
  logic [3:0] bus_en_n = 4'hF;
  logic [15:0] test_word = '0;
  logic test_en = 0, use_test_data = 0, use_test_en = 0, interp_mode = 0;
  logic offset_bin = 0, float_en = 0, sync_in = 0;
  logic [1:0] src_sel = '0, float_split = '0;
  logic [2:0] demux_dly = '0;
  logic [15:0] out_data;
  logic out_valid;

  int tests = 0, fails = 0, cyc = 0, gcnt = 0;
  logic [15:0] got [0:15];
  bit done = 0;

  always #5 clk = ~clk;

  sample_front_end u0 (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_en_n(bus_en_n),
    .test_word(test_word), .test_en(test_en), .src_sel(src_sel),
    .use_test_data(use_test_data), .use_test_en(use_test_en),
    .interp_mode(interp_mode), .offset_bin(offset_bin), .float_en(float_en),
    .float_split(float_split), .demux_dly(demux_dly), .sync_in(sync_in),
    .out_data(out_data), .out_valid(out_valid)
  );

  // {req[3:0], src[2:0] (4 = test word), offset, float, split[1:0], word, expected}
  localparam int NV = 15;
  localparam logic [42:0] VEC [NV] = '{
    {4'd1, 3'd0, 1'b0, 1'b0, 2'd0, 16'h1234, 16'h1234},  // R1
    {4'd7, 3'd1, 1'b1, 1'b0, 2'd0, 16'h8000, 16'h0000},  // R7
    {4'd7, 3'd2, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h8000},
    {4'd7, 3'd3, 1'b1, 1'b0, 2'd0, 16'hFFFF, 16'h7FFF},
    {4'd1, 3'd4, 1'b0, 1'b0, 2'd0, 16'hBEEF, 16'hBEEF},  // R1 test word
    {4'd8, 3'd0, 1'b0, 1'b1, 2'd0, 16'h002A, 16'h0014},  // R8
    {4'd8, 3'd1, 1'b0, 1'b1, 2'd0, 16'hFFFF, 16'hFF80},
    {4'd8, 3'd2, 1'b0, 1'b1, 2'd1, 16'h7FE9, 16'hFFFA},
    {4'd8, 3'd3, 1'b0, 1'b1, 2'd2, 16'h0323, 16'h0320},
    {4'd8, 3'd0, 1'b0, 1'b1, 2'd3, 16'h8000, 16'hE000},
    {4'd8, 3'd1, 1'b0, 1'b1, 2'd3, 16'h3FFF, 16'h7FF8},
    {4'd9, 3'd2, 1'b0, 1'b1, 2'd0, 16'h1FFF, 16'h7FFF},  // R9
    {4'd9, 3'd3, 1'b0, 1'b1, 2'd0, 16'h2007, 16'h8000},
    {4'd9, 3'd0, 1'b0, 1'b1, 2'd3, 16'h4003, 16'h7FFF},
    {4'd7, 3'd1, 1'b1, 1'b1, 2'd0, 16'h002A, 16'h0014}   // R7 ignored in float
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_bus(input int src, input logic [15:0] w);
    for (int b = 0; b < 4; b++)
      bus_data[b*16 +: 16] = (b == src) ? w : (w ^ 16'h5A5A ^ 16'(b));
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic grab();
    if (out_valid && gcnt < 16) got[gcnt] = out_data;
    if (out_valid) gcnt++;
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    int cnt;
    tick(3);
    rst_n = 1;
    tick(1);
    // R3 reset state
    chk("R3 reset valid", 16'(out_valid), 16'h0);
    chk("R3 reset data", out_data, 16'h0);

    // R3 enables blocked before sync
    bus_en_n = 4'h0;
    set_bus(0, 16'h1111);
    cnt = 0;
    for (int i = 0; i < 6; i++) begin tick(1); if (out_valid) cnt++; end
    chk("R3 no valid before sync", 16'(cnt), 16'h0);
    sync_in = 1;
    tick(1);
    sync_in = 0;
    tick(2);
    chk("R3 still idle 3 clocks after sync", 16'(out_valid), 16'h0);
    tick(1);
    chk("R3 valid 4 clocks after sync", 16'(out_valid), 16'h1);
    chk("R3 first data", out_data, 16'h1111);

    // table: R1 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      logic [42:0] e;
      e = VEC[v];
      if (e[38:36] == 3'd4) begin
        use_test_data = 1; test_word = e[31:16]; src_sel = 2'd0; set_bus(9, 16'h0F0F);
      end else begin
        use_test_data = 0; src_sel = e[37:36]; set_bus(int'(e[38:36]), e[31:16]);
      end
      offset_bin = e[35]; float_en = e[34]; float_split = e[33:32];
      tick(4);
      chk($sformatf("R%0d vec %0d valid", e[42:39], v), 16'(out_valid), 16'h1);
      chk($sformatf("R%0d vec %0d data", e[42:39], v), out_data, e[15:0]);
    end
    use_test_data = 0; offset_bin = 0; float_en = 0; float_split = 0;

    // R2 enable selection
    src_sel = 2'd2; set_bus(2, 16'h0777); bus_en_n = 4'b1110;
    tick(3);
    cnt = 0;
    for (int i = 0; i < 6; i++) begin tick(1); if (out_valid) cnt++; end
    chk("R2 unselected bus enable ignored", 16'(cnt), 16'h0);
    use_test_en = 1; test_en = 1;
    tick(4);
    chk("R2 test enable valid", 16'(out_valid), 16'h1);
    chk("R2 test enable data", out_data, 16'h0777);
    use_test_en = 0; test_en = 0; bus_en_n = 4'b1011;
    tick(4);
    chk("R2 selected bus enable", 16'(out_valid), 16'h1);
    bus_en_n = 4'hF;
    tick(4);

    // R4 gated stalls
    src_sel = 2'd0; gcnt = 0;
    for (int i = 0; i < 18; i++) begin
      grab();
      set_bus(0, 16'(16'h10 * (i + 1)));
      bus_en_n = (i == 1 || i == 4 || i == 5 || i == 9) ? 4'hE : 4'hF;
      tick(1);
    end
    chk("R4 valid count", 16'(gcnt), 16'h4);
    chk("R4 out 0", got[0], 16'h0777);
    chk("R4 out 1", got[1], 16'h0020);
    chk("R4 out 2", got[2], 16'h0050);
    chk("R4 out 3", got[3], 16'h0060);
    chk("R4 data held while idle", out_data, 16'h0060);

    // R6 demultiplex
    for (int k = 0; k < 3; k++) begin
      int d;
      d = (k == 0) ? 0 : (k == 1) ? 3 : 7;
      demux_dly = 3'(d); gcnt = 0;
      for (int t = 0; t < 44; t++) begin
        grab();
        if (t < 32) begin
          set_bus(0, 16'(16'h100 * (t / 8 + 1) + t % 8));
          bus_en_n = (t % 8 == 0) ? 4'hE : 4'hF;
        end else bus_en_n = 4'hF;
        tick(1);
      end
      chk($sformatf("R6 dly %0d count", d), 16'(gcnt), 16'h4);
      for (int f = 1; f < 4; f++)
        chk($sformatf("R6 dly %0d frame %0d", d, f), got[f], 16'(16'h100 * f + d));
    end
    demux_dly = 0;

    // R5 interpolated zero stuffing
    interp_mode = 1;
    for (int i = 0; i < 15; i++) begin
      if (i >= 3) begin
        int k;
        k = i - 3;
        chk("R5 interp valid", 16'(out_valid), 16'h1);
        chk($sformatf("R5 interp sample %0d", k), out_data,
            (k % 3 == 0) ? 16'(16'h100 * (k + 1)) : 16'h0000);
      end
      if (i < 12) begin
        set_bus(0, 16'(16'h100 * (i + 1)));
        bus_en_n = (i % 3 == 0) ? 4'hE : 4'hF;
      end else begin
        set_bus(0, 16'h7777); bus_en_n = 4'hF;
      end
      tick(1);
    end
    finish_run();
  end
endmodule